// File: doc/BRIEF.md
# Extended Effective Address Generator

This block turns the 17-bit reference field of an instruction word into a 20-bit word effective address and a 2-bit byte offset. It does this only when two program-status mode bits select extended real addressing. The caller presents the instruction, the two mode bits, the operand size and the 32-bit contents of the index register that the instruction's index field names, all together with a one-cycle `start` pulse. If the instruction asks for indirection, the block first reads one indirect word through a request/valid handshake. It then aligns the index value to the operand size, adds it and truncates the sum. The result is delivered with a one-cycle `done` pulse.

The controller is a three-state machine:
- `ST_IDLE` waits for `start`. From there, the transition *launch-fetch* goes to `ST_FETCH` when extended mode and indirection are both requested, and the transition *direct* goes to `ST_FINISH` in every other case.
- `ST_FETCH` holds the memory request until the indirect word arrives. The transition *word-back* then moves it to `ST_FINISH`.
- `ST_FINISH` spends one cycle forming the registered result. The transition *deliver* returns it to `ST_IDLE` while `done` is raised.

Top module: `ext_ea_gen`

## Requirements
- R1: Extended mode is active only when `stat_map` is 0 and `stat_ext` is 1. In any other combination the block ignores the index and indirect requests, issues no memory request, and reports `ea_word` = zero-extended `instr[16:0]`, `ea_byte` = 0 and `not_ext` = 1. In extended mode `not_ext` is 0.
- R2: In extended mode, when there is no indexing and no indirection, `ea_word` is `instr[16:0]` with three zero bits on top and `ea_byte` is 0. `done` is high during the cycle after the clock edge that sampled `start`.
- R3: The index field is `instr[19:17]`. Indexing applies only when this field is nonzero. When it is zero, `index_val` has no effect on the result.
- R4: Operand size encoding is 0 = byte, 1 = halfword, 2 = word, 3 = doubleword, 4 = shift (5 to 7 behave as word). For a byte operand the 22-bit sum is base·4 + index. Its upper 20 bits form `ea_word` and its low 2 bits form `ea_byte`.
- R5: For a halfword operand the 21-bit sum is base·2 + index. Its upper 20 bits form `ea_word`, and `ea_byte` is {sum bit 0, 0}.
- R6: For word and shift operands the 20-bit sum is base + index, and `ea_byte` is 0.
- R7: For a doubleword operand the 20-bit sum is base + index·2, with bit 0 of `ea_word` forced to 0, and `ea_byte` is 0. The forcing applies also when there is no indexing.
- R8: Carries out of the 22/21/20-bit sums are discarded, so an address wraps modulo 2^20 words.
- R9: Indirection is requested by `instr[31]` = 1. In extended mode, `mem_req` and `busy` rise in the cycle after `start` is sampled, with `mem_addr` = zero-extended `instr[16:0]`. Both stay high until `mem_valid` is sampled and drop after that edge. The low 20 bits of `mem_rdata` then replace the base.
- R10: After an indirect fetch, alignment and addition use the fetched base. `done` is high during the cycle after the one in which `busy` was last low-going, that is, one edge after `mem_valid` was sampled.
- R11: `start` is ignored while the block is in `ST_FETCH` or `ST_FINISH`.
- R12: After reset, `busy`, `mem_req` and `done` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle request to compute an address |
| instr | input | 32 | Instruction word: bit 31 indirect, [19:17] index field, [16:0] reference |
| stat_map | input | 1 | Status mode bit that must be 0 for extended mode |
| stat_ext | input | 1 | Status mode bit that must be 1 for extended mode |
| index_val | input | 32 | Contents of the selected index register |
| op_size | input | 3 | Operand size code |
| mem_req | output | 1 | Indirect word read request |
| mem_addr | output | 20 | Word address of the indirect word |
| mem_valid | input | 1 | Indirect word is present on `mem_rdata` |
| mem_rdata | input | 32 | Indirect word |
| busy | output | 1 | Waiting for the indirect word |
| done | output | 1 | One-cycle pulse: result is valid |
| ea_word | output | 20 | Effective word address |
| ea_byte | output | 2 | Byte offset within the word |
| not_ext | output | 1 | Result came from the non-extended pass-through |

## Verification
Results with no fetch are due one cycle after the edge that samples `start`. Fetched results are due one cycle after the edge that samples `mem_valid`. `mem_req` and `busy` change one edge after the event that causes them. The bench model advances on the same rising edge as the design, and every output is compared on the falling edge that follows. Each expected value is therefore checked in exactly the cycle in which it becomes due, and never a cycle early or late.

// File: rtl/ext_ea_pkg.sv
package ext_ea_pkg;

    typedef enum logic [2:0] {
        SZ_BYTE  = 3'd0,
        SZ_HALF  = 3'd1,
        SZ_WORD  = 3'd2,
        SZ_DBL   = 3'd3,
        SZ_SHIFT = 3'd4
    } opsz_e;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_FETCH  = 2'd1,
        ST_FINISH = 2'd2
    } eag_state_e;

endpackage

// File: rtl/ext_ea_decode.sv
module ext_ea_decode #(
    parameter int DATA_W = 32,
    parameter int REF_W  = 17,
    parameter int XF_W   = 3
) (
    input  logic [DATA_W-1:0] instr,
    input  logic              stat_map,
    input  logic              stat_ext,
    output logic              ext_mode,
    output logic              ind_req,
    output logic              idx_req,
    output logic [REF_W-1:0]  ref_field
);
    localparam int XF_LSB  = REF_W;
    localparam int IND_BIT = DATA_W - 1;
    localparam int GAP_LO  = XF_LSB + XF_W;

    logic [IND_BIT-GAP_LO-1:0] gap_unused;

    // mode pair: first bit must be clear, second set (R1)
    assign ext_mode  = !stat_map && stat_ext;
    assign ind_req   = ext_mode && instr[IND_BIT];
    // nonzero index field selects indexing (R3)
    assign idx_req   = ext_mode && (|instr[XF_LSB +: XF_W]);
    assign ref_field = instr[REF_W-1:0];
    assign gap_unused = instr[IND_BIT-1:GAP_LO];

endmodule

// File: rtl/ext_ea_align.sv
module ext_ea_align
    import ext_ea_pkg::*;
#(
    parameter int EA_W   = 20,
    parameter int DATA_W = 32
) (
    input  logic [EA_W-1:0]   base,
    input  logic [DATA_W-1:0] index,
    input  logic              use_idx,
    input  logic [2:0]        size,
    output logic [EA_W-1:0]   word,
    output logic [1:0]        boff
);
    localparam int BW = EA_W + 2;   // byte-granular sum width
    localparam int HW = EA_W + 1;   // halfword-granular sum width

    logic [BW-1:0]          xv;
    logic [DATA_W-BW-1:0]   hi_unused;
    logic [BW-1:0]          sum_b;
    logic [HW-1:0]          sum_h;
    logic [EA_W-1:0]        sum_w;
    logic [EA_W-1:0]        sum_d;

    // bits above the widest sum only reach discarded carries (R8)
    assign xv        = use_idx ? index[BW-1:0] : '0;
    assign hi_unused = index[DATA_W-1:BW];

    assign sum_b = {base, 2'b00} + xv;                       // R4
    assign sum_h = {base, 1'b0} + xv[HW-1:0];                // R5
    assign sum_w = base + xv[EA_W-1:0];                      // R6
    assign sum_d = base + {xv[EA_W-2:0], 1'b0};              // R7

    always_comb begin
        word = sum_w;
        boff = 2'b00;
        case (size)
            SZ_BYTE: begin
                word = sum_b[BW-1:2];
                boff = sum_b[1:0];
            end
            SZ_HALF: begin
                word = sum_h[HW-1:1];
                boff = {sum_h[0], 1'b0};
            end
            SZ_DBL: begin
                word = {sum_d[EA_W-1:1], 1'b0};
                boff = 2'b00;
            end
            default: begin
                word = sum_w;
                boff = 2'b00;
            end
        endcase
    end

endmodule

// File: rtl/ext_ea_gen.sv
module ext_ea_gen
    import ext_ea_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int REF_W  = 17,
    parameter int EA_W   = 20,
    parameter int XF_W   = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [DATA_W-1:0] instr,
    input  logic              stat_map,
    input  logic              stat_ext,
    input  logic [DATA_W-1:0] index_val,
    input  logic [2:0]        op_size,
    output logic              mem_req,
    output logic [EA_W-1:0]   mem_addr,
    input  logic              mem_valid,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              busy,
    output logic              done,
    output logic [EA_W-1:0]   ea_word,
    output logic [1:0]        ea_byte,
    output logic              not_ext
);
    localparam int EXT_W = EA_W - REF_W;

    eag_state_e state_q, state_d;

    logic              dec_ext, dec_ind, dec_idx;
    logic [REF_W-1:0]  dec_ref;

    logic              ext_q, idx_q;
    logic [2:0]        size_q;
    logic [DATA_W-1:0] index_q;
    logic [REF_W-1:0]  ref_q;
    logic [EA_W-1:0]   base_q;
    logic [DATA_W-EA_W-1:0] rdata_unused;

    logic [EA_W-1:0]   al_word;
    logic [1:0]        al_boff;

    ext_ea_decode #(
        .DATA_W (DATA_W),
        .REF_W  (REF_W),
        .XF_W   (XF_W)
    ) u_decode (
        .instr     (instr),
        .stat_map  (stat_map),
        .stat_ext  (stat_ext),
        .ext_mode  (dec_ext),
        .ind_req   (dec_ind),
        .idx_req   (dec_idx),
        .ref_field (dec_ref)
    );

    ext_ea_align #(
        .EA_W   (EA_W),
        .DATA_W (DATA_W)
    ) u_align (
        .base    (base_q),
        .index   (index_q),
        .use_idx (idx_q),
        .size    (size_q),
        .word    (al_word),
        .boff    (al_boff)
    );

    assign rdata_unused = mem_rdata[DATA_W-1:EA_W];

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // transitions: launch-fetch, direct, word-back, deliver
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start) state_d = dec_ind ? ST_FETCH : ST_FINISH;
            end
            ST_FETCH: begin
                if (mem_valid) state_d = ST_FINISH;
            end
            ST_FINISH: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // operand capture; start is only taken in ST_IDLE (R11)
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ext_q   <= 1'b0;
            idx_q   <= 1'b0;
            size_q  <= 3'd0;
            index_q <= '0;
            ref_q   <= '0;
            base_q  <= '0;
        end else if (state_q == ST_IDLE && start) begin
            ext_q   <= dec_ext;
            idx_q   <= dec_idx;
            size_q  <= op_size;
            index_q <= index_val;
            ref_q   <= dec_ref;
            base_q  <= {{EXT_W{1'b0}}, dec_ref};
        end else if (state_q == ST_FETCH && mem_valid) begin
            base_q  <= mem_rdata[EA_W-1:0];   // R9 fetched base
        end
    end

    // outputs
    assign mem_req  = (state_q == ST_FETCH);
    assign busy     = (state_q == ST_FETCH);
    assign mem_addr = {{EXT_W{1'b0}}, ref_q};

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done    <= 1'b0;
            ea_word <= '0;
            ea_byte <= 2'b00;
            not_ext <= 1'b0;
        end else begin
            done <= (state_q == ST_FINISH);
            if (state_q == ST_FINISH) begin
                ea_word <= ext_q ? al_word : {{EXT_W{1'b0}}, ref_q};
                ea_byte <= ext_q ? al_boff : 2'b00;
                not_ext <= !ext_q;
            end
        end
    end

    p_req_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_valid |=> mem_req);

    p_req_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && mem_valid |=> !mem_req);

    p_done_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_done_after_fetch_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |=> done);

    p_passthru_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
        done && not_ext |-> (ea_word[EA_W-1:REF_W] == '0) && (ea_byte == 2'b00));

    p_dbl_even_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done && !not_ext && (size_q == SZ_DBL) |-> !ea_word[0]);

    p_no_done_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !done);

endmodule

// File: tb/test_ext_ea_gen.sv
module test_ext_ea_gen;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] instr = '0;
    logic        stat_map = 1'b0;
    logic        stat_ext = 1'b1;
    logic [31:0] index_val = '0;
    logic [2:0]  op_size = 3'd2;
    logic        mem_valid = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic        mem_req, busy, done, not_ext;
    logic [19:0] mem_addr, ea_word;
    logic [1:0]  ea_byte;

    always #2.5 clk = ~clk;   // 200 MHz

    ext_ea_gen i_ext_ea_gen (
        .clk(clk), .rst_n(rst_n), .start(start), .instr(instr),
        .stat_map(stat_map), .stat_ext(stat_ext), .index_val(index_val),
        .op_size(op_size), .mem_req(mem_req), .mem_addr(mem_addr),
        .mem_valid(mem_valid), .mem_rdata(mem_rdata), .busy(busy),
        .done(done), .ea_word(ea_word), .ea_byte(ea_byte), .not_ext(not_ext)
    );

    int errors = 0;
    int checks = 0;
    int cycles = 0;
    string tag = "R12";

    // behavioural reference model
    int          m_phase = 0;      // 0 wait, 1 fetching, 2 finishing
    bit          m_busy = 0, m_done = 0, m_ext = 0, m_idx = 0;
    int          m_size = 0;
    longint      m_index = 0, m_ref = 0, m_base = 0;
    longint      m_word = 0, m_off = 0;
    bit          m_nx = 0;

    task automatic check(input string t, input longint act, input longint exp, input string what);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", t, what, act, exp);
        end
    endtask

    task automatic summary;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (!rst_n) begin
            m_phase = 0; m_busy = 0; m_done = 0;
        end else begin
            m_done = 0;
            if (m_phase == 0) begin
                if (start) begin
                    m_ext   = (stat_map == 1'b0) && (stat_ext == 1'b1);
                    m_idx   = m_ext && (instr[19:17] != 3'd0);
                    m_size  = int'(op_size);
                    m_index = longint'(index_val);
                    m_ref   = longint'(instr[16:0]);
                    m_base  = m_ref;
                    if (m_ext && instr[31]) begin
                        m_phase = 1; m_busy = 1;
                    end else m_phase = 2;
                end
            end else if (m_phase == 1) begin
                if (mem_valid) begin
                    m_base = longint'(mem_rdata[19:0]);
                    m_phase = 2; m_busy = 0;
                end
            end else begin
                longint x, t;
                x = m_idx ? m_index : 0;
                m_done = 1;
                m_phase = 0;
                if (!m_ext) begin
                    m_word = m_ref; m_off = 0; m_nx = 1;
                end else begin
                    m_nx = 0;
                    if (m_size == 0) begin
                        t = (m_base * 4 + x) % (64'd1 << 22);
                        m_word = t / 4; m_off = t % 4;
                    end else if (m_size == 1) begin
                        t = (m_base * 2 + x) % (64'd1 << 21);
                        m_word = t / 2; m_off = (t % 2) * 2;
                    end else if (m_size == 3) begin
                        t = (m_base + x * 2) % (64'd1 << 20);
                        m_word = (t / 2) * 2; m_off = 0;
                    end else begin
                        t = (m_base + x) % (64'd1 << 20);
                        m_word = t; m_off = 0;
                    end
                end
            end
        end
    end

    // compare every cycle, away from the rising edge
    always @(negedge clk) begin
        if (rst_n) begin
            check("R9/R11", {busy, mem_req, done}, {m_busy, m_busy, m_done}, "busy/req/done");
            if (m_busy) check("R9", mem_addr, m_ref, "mem_addr");
            if (m_done) begin
                check(tag, ea_word, m_word, "ea_word");
                check(tag, ea_byte, m_off, "ea_byte");
                check("R1", not_ext, m_nx, "not_ext");
            end
        end
        if (cycles > 100000) begin
            errors++; checks++;
            $display("FAIL watchdog expired");
            summary();
        end
    end

    task automatic run(input string t, input bit smap, input bit sext, input bit ind,
                       input [2:0] xf, input [16:0] rf, input [31:0] idx, input [2:0] sz,
                       input [31:0] iword, input int dly, input bit poke);
        tag = t;
        @(negedge clk);
        instr = {ind, 11'h5A5, xf, rf};
        stat_map = smap; stat_ext = sext; index_val = idx; op_size = sz;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        instr = 32'hFFFF_FFFF; index_val = 32'h1234_5678; op_size = 3'd0;
        if (ind && !smap && sext) begin
            while (!mem_req) @(negedge clk);
            for (int k = 0; k < dly; k++) begin
                if (poke) start = (k == 0);   // R11: start while fetching
                @(negedge clk);
            end
            start = 1'b0;
            mem_valid = 1'b1; mem_rdata = iword;
            @(negedge clk);
            mem_valid = 1'b0; mem_rdata = 32'hDEAD_BEEF;
        end
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R12", {busy, mem_req, done}, 3'b000, "reset outputs");
        rst_n = 1'b1;
        @(negedge clk);
        // R1: mode pair not selecting extended mode
        run("R1", 1, 1, 1, 3'd2, 17'h1F0F3, 32'h100, 3'd0, 0, 0, 0);
        run("R1", 0, 0, 1, 3'd1, 17'h00007, 32'h3, 3'd1, 0, 0, 0);
        run("R1", 1, 0, 0, 3'd0, 17'h0ABCD, 32'h0, 3'd2, 0, 0, 0);
        // R2: plain extended
        run("R2", 0, 1, 0, 3'd0, 17'h1ABCD, 32'h0, 3'd2, 0, 0, 0);
        // R3: zero index field, index value ignored
        run("R3", 0, 1, 0, 3'd0, 17'h00010, 32'h00FF_FFF7, 3'd0, 0, 0, 0);
        // R4 byte
        run("R4", 0, 1, 0, 3'd3, 17'h00010, 32'h7, 3'd0, 0, 0, 0);
        // R5 halfword
        run("R5", 0, 1, 0, 3'd1, 17'h00011, 32'h5, 3'd1, 0, 0, 0);
        // R6 word and shift
        run("R6", 0, 1, 0, 3'd4, 17'h01000, 32'h0004_0123, 3'd2, 0, 0, 0);
        run("R6", 0, 1, 0, 3'd4, 17'h01000, 32'h0000_0321, 3'd4, 0, 0, 0);
        // R7 doubleword, odd base with and without index
        run("R7", 0, 1, 0, 3'd5, 17'h00101, 32'h3, 3'd3, 0, 0, 0);
        run("R7", 0, 1, 0, 3'd0, 17'h00101, 32'h3, 3'd3, 0, 0, 0);
        // R8 wraparound
        run("R8", 0, 1, 0, 3'd7, 17'h1FFFF, 32'hFFFF_FFFF, 3'd0, 0, 0, 0);
        run("R8", 0, 1, 0, 3'd7, 17'h1FFFF, 32'h00F0_0001, 3'd2, 0, 0, 0);
        // R9 indirect, immediate answer
        run("R9", 0, 1, 1, 3'd0, 17'h0F00D, 32'h0, 3'd2, 32'hFFF1_2345, 0, 0);
        // R10 indirect plus index, slow answer, R11 start during fetch
        run("R10", 0, 1, 1, 3'd6, 17'h00042, 32'h0000_0013, 3'd0, 32'h000F_FFFE, 3, 1);
        run("R10", 0, 1, 1, 3'd6, 17'h00042, 32'h0000_0009, 3'd3, 32'h8001_0003, 2, 0);
        summary();
    end

endmodule